// File: doc/BRIEF.md
# Packed Horizontal Pairwise Subtractor

This unit is a SIMD datapath stage. It takes two packed source vectors and, in each one, splits the lanes into adjacent pairs. For every pair it subtracts the upper (more significant) element from the lower one. The differences are then packed into a single destination vector. Elements are signed and either 16 or 32 bits wide. Each difference has the same width as its inputs and wraps modulo 2^n.

The operand width can be 64, 128 or 256 bits. At 256 bits the work is done separately on each 128-bit half. The packed result is merged into a 256-bit image of the old destination register. In the 128-bit case the bits above bit 127 are kept in the legacy encoding style and cleared in the three-operand style.

A second source that is read from memory at 128-bit width in the legacy style must be 16-byte aligned. If it is not, the unit raises a protection fault flag and returns the old destination image unchanged. Results, the fault flag and a valid strobe are registered one cycle after the input strobe.

Top module: `hsub_pair_unit`

## Requirements
- R1: Every result element equals the lower-indexed element of its pair minus the higher-indexed element, computed modulo 2^n with no saturation.
- R2: `elem32`=0 selects signed 16-bit elements, and `elem32`=1 selects signed 32-bit elements.
- R3: Within each result region, the differences from `src_a` fill the lower half and the differences from `src_b` fill the upper half. In both halves, pair k is placed at element position k, in ascending order.
- R4: `vlen`=2'b00 (64-bit) uses bits 63:0 of each source and writes `res[63:0]`. `res[255:64]` equals `dst_old[255:64]`.
- R5: `vlen`=2'b01 (128-bit) with `three_op`=0 writes `res[127:0]` and keeps `res[255:128]` equal to `dst_old[255:128]`.
- R6: `vlen`=2'b01 with `three_op`=1 writes `res[127:0]` and clears `res[255:128]` to zero.
- R7: `vlen`=2'b10 or 2'b11 (256-bit) processes bits 127:0 and bits 255:128 as two independent regions, with no pair crossing bit 128. `three_op` has no effect in this mode.
- R8: When `src_b_mem`=1, `vlen`=2'b01, `three_op`=0 and `src_b_addr[3:0]`≠0, the unit sets `fault`=1 and makes `res` equal to `dst_old`.
- R9: In every other case `fault`=0. This includes an aligned address, the three-operand style, the 64-bit and 256-bit widths, and a register source.
- R10: Overflow wraps. For 16-bit elements, 0x8000−0x0001 gives 0x7FFF and 0x7FFF−0xFFFF gives 0x8000. For 32-bit elements, 0x80000000−0x00000001 gives 0x7FFFFFFF.
- R11: `out_valid` is high for exactly one cycle, in the cycle after each `in_valid` cycle. `res` and `fault` hold their value until the next `in_valid`. Reset clears `res`, `fault` and `out_valid` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid strobe |
| src_a | input | 256 | First source vector |
| src_b | input | 256 | Second source vector |
| dst_old | input | 256 | Previous destination register image |
| elem32 | input | 1 | 0: 16-bit elements, 1: 32-bit elements |
| vlen | input | 2 | 00: 64-bit, 01: 128-bit, 1x: 256-bit |
| three_op | input | 1 | 1: three-operand style (zero upper bits), 0: legacy style |
| src_b_mem | input | 1 | Second source was read from memory |
| src_b_addr | input | 48 | Byte address of the memory source |
| res | output | 256 | Merged destination image |
| fault | output | 1 | Protection fault for a misaligned source |
| out_valid | output | 1 | Result valid strobe |

## Verification
Every output comes from one register stage. The bench therefore drives an operation on a falling edge and holds `in_valid` through one rising edge. It compares `res`, `fault` and `out_valid` at the next falling edge, which is the first point where that edge's capture can be seen. One falling edge later it checks that `out_valid` has dropped and that `res` has held, even though the inputs were changed in between. Each mode has its own directed task. A closing random pass covers all mode combinations and compares against a lane-by-lane model built with shifts and masks.

// File: rtl/hsub_pkg.sv
package hsub_pkg;
  localparam int DEST_W   = 256;
  localparam int REGION_W = 128;
  localparam int NARROW_W = 64;
  localparam int NREGION  = DEST_W / REGION_W;

  typedef enum logic [1:0] {
    VL_64   = 2'b00,
    VL_128  = 2'b01,
    VL_256  = 2'b10,
    VL_256X = 2'b11
  } vlen_e;
endpackage

// File: rtl/hsub_pack.sv
// Pairwise subtract within one region of width W: src a -> low half, src b -> high half.
module hsub_pack #(
  parameter int W = 128
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         elem32,
  output logic [W-1:0] r
);
  localparam int HALF = W / 2;
  localparam int NW   = W / 32;  // word pairs per source
  localparam int ND   = W / 64;  // dword pairs per source

  logic [W-1:0] rw;
  logic [W-1:0] rd;

  generate
    for (genvar i = 0; i < NW; i++) begin : g_word
      assign rw[16*i +: 16]        = a[32*i +: 16] - a[32*i+16 +: 16];
      assign rw[HALF+16*i +: 16]   = b[32*i +: 16] - b[32*i+16 +: 16];
    end
    for (genvar j = 0; j < ND; j++) begin : g_dword
      assign rd[32*j +: 32]        = a[64*j +: 32] - a[64*j+32 +: 32];
      assign rd[HALF+32*j +: 32]   = b[64*j +: 32] - b[64*j+32 +: 32];
    end
  endgenerate

  assign r = elem32 ? rd : rw;
endmodule

// File: rtl/hsub_fault.sv
// Alignment fault detection for a legacy-style 128-bit memory source.
module hsub_fault #(
  parameter int ADDR_W     = 48,
  parameter int ALIGN_LOG2 = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_mem,
  input  logic [1:0]        vlen,
  input  logic              three_op,
  output logic              flt
);
  import hsub_pkg::*;
  logic unused_addr_hi;
  assign unused_addr_hi = ^addr[ADDR_W-1:ALIGN_LOG2];

  assign flt = is_mem && (vlen == VL_128) && !three_op &&
               (addr[ALIGN_LOG2-1:0] != '0);
endmodule

// File: rtl/hsub_merge.sv
// Merge packed results into the destination image by width and encoding style.
module hsub_merge #(
  parameter int DEST_W   = 256,
  parameter int REGION_W = 128,
  parameter int NARROW_W = 64,
  parameter int NREGION  = 2
) (
  input  logic [NARROW_W-1:0]          r_narrow,
  input  logic [NREGION*REGION_W-1:0]  r_wide,
  input  logic [DEST_W-NARROW_W-1:0]   old_hi,
  input  logic [1:0]                   vlen,
  input  logic                         three_op,
  output logic [DEST_W-1:0]            merged
);
  import hsub_pkg::*;
  localparam int KEEP_W = DEST_W - REGION_W;

  always_comb begin
    unique case (vlen)
      VL_64:   merged = {old_hi, r_narrow};
      VL_128:  merged = {(three_op ? {KEEP_W{1'b0}} : old_hi[DEST_W-NARROW_W-1 -: KEEP_W]),
                         r_wide[REGION_W-1:0]};
      default: merged = r_wide;
    endcase
  end
endmodule

// File: rtl/hsub_pair_unit.sv
module hsub_pair_unit #(
  parameter int ADDR_W     = 48,
  parameter int ALIGN_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [255:0]      src_a,
  input  logic [255:0]      src_b,
  input  logic [255:0]      dst_old,
  input  logic              elem32,
  input  logic [1:0]        vlen,
  input  logic              three_op,
  input  logic              src_b_mem,
  input  logic [ADDR_W-1:0] src_b_addr,
  output logic [255:0]      res,
  output logic              fault,
  output logic              out_valid
);
  import hsub_pkg::*;

  logic [NARROW_W-1:0]         r_narrow;
  logic [NREGION*REGION_W-1:0] r_wide;
  logic [DEST_W-1:0]           merged;
  logic                        flt;

  hsub_pack #(.W(NARROW_W)) u_narrow (
    .a(src_a[NARROW_W-1:0]), .b(src_b[NARROW_W-1:0]),
    .elem32(elem32), .r(r_narrow)
  );

  generate
    for (genvar g = 0; g < NREGION; g++) begin : g_region
      hsub_pack #(.W(REGION_W)) u_region (
        .a(src_a[g*REGION_W +: REGION_W]), .b(src_b[g*REGION_W +: REGION_W]),
        .elem32(elem32), .r(r_wide[g*REGION_W +: REGION_W])
      );
    end
  endgenerate

  hsub_merge #(.DEST_W(DEST_W), .REGION_W(REGION_W), .NARROW_W(NARROW_W),
               .NREGION(NREGION)) u_merge (
    .r_narrow(r_narrow), .r_wide(r_wide),
    .old_hi(dst_old[DEST_W-1:NARROW_W]),
    .vlen(vlen), .three_op(three_op), .merged(merged)
  );

  hsub_fault #(.ADDR_W(ADDR_W), .ALIGN_LOG2(ALIGN_LOG2)) u_fault (
    .addr(src_b_addr), .is_mem(src_b_mem), .vlen(vlen),
    .three_op(three_op), .flt(flt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res       <= '0;
      fault     <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res   <= flt ? dst_old : merged;
        fault <= flt;
      end
    end
  end
endmodule

// File: rtl/hsub_pair_chk.sv
module hsub_pair_chk #(
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [255:0]      dst_old,
  input logic [1:0]        vlen,
  input logic              three_op,
  input logic              src_b_mem,
  input logic [ADDR_W-1:0] src_b_addr,
  input logic [255:0]      res,
  input logic              fault,
  input logic              out_valid
);
  logic misal;
  assign misal = src_b_mem && (vlen == 2'b01) && !three_op && (src_b_addr[3:0] != 4'h0);

  // R11
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R11
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(res) && $stable(fault));
  // R4
  narrow_keep_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && vlen == 2'b00 |=> res[255:64] == $past(dst_old[255:64]));
  // R5
  legacy_keep_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && vlen == 2'b01 && !three_op |=> res[255:128] == $past(dst_old[255:128]));
  // R6
  three_op_zero_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && vlen == 2'b01 && three_op |=> res[255:128] == '0);
  // R8
  fault_set_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && misal |=> fault && res == $past(dst_old));
  // R9
  fault_clear_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && !misal |=> !fault);
endmodule

bind hsub_pair_unit hsub_pair_chk #(.ADDR_W(ADDR_W)) u_hsub_pair_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .dst_old(dst_old), .vlen(vlen),
  .three_op(three_op), .src_b_mem(src_b_mem), .src_b_addr(src_b_addr),
  .res(res), .fault(fault), .out_valid(out_valid)
);

// File: tb/test_hsub_pair_unit.sv
module test_hsub_pair_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [255:0] src_a = '0, src_b = '0, dst_old = '0;
  logic         elem32 = 1'b0;
  logic [1:0]   vlen = 2'b00;
  logic         three_op = 1'b0, src_b_mem = 1'b0;
  logic [47:0]  src_b_addr = '0;
  logic [255:0] res;
  logic         fault, out_valid;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  hsub_pair_unit i_hsub_pair_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .dst_old(dst_old), .elem32(elem32), .vlen(vlen), .three_op(three_op),
    .src_b_mem(src_b_mem), .src_b_addr(src_b_addr),
    .res(res), .fault(fault), .out_valid(out_valid)
  );

  function automatic logic [255:0] rnd256();
    return {$urandom(), $urandom(), $urandom(), $urandom(),
            $urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  function automatic logic ref_flt(logic m, logic [1:0] vl, logic t3, logic [47:0] ad);
    return m && vl == 2'b01 && !t3 && ad[3:0] != 4'h0;
  endfunction

  function automatic logic [255:0] ref_res(logic [255:0] a, logic [255:0] b, logic [255:0] o,
      logic e32, logic [1:0] vl, logic t3, logic m, logic [47:0] ad);
    logic [255:0] out;
    logic [31:0] mask, x, y;
    int w, nreg, es;
    if (ref_flt(m, vl, t3, ad)) return o;
    es   = e32 ? 32 : 16;
    mask = e32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    w    = (vl == 2'b00) ? 64 : 128;
    nreg = vl[1] ? 2 : 1;
    if (vl == 2'b00) out = {o[255:64], 64'b0};
    else if (vl == 2'b01 && !t3) out = {o[255:128], 128'b0};
    else out = '0;
    for (int r = 0; r < nreg; r++) begin
      for (int k = 0; k < w / (2 * es); k++) begin
        x = 32'(a >> (r*128 + 2*k*es)) & mask;
        y = 32'(a >> (r*128 + (2*k+1)*es)) & mask;
        out |= 256'((x - y) & mask) << (r*128 + k*es);
        x = 32'(b >> (r*128 + 2*k*es)) & mask;
        y = 32'(b >> (r*128 + (2*k+1)*es)) & mask;
        out |= 256'((x - y) & mask) << (r*128 + w/2 + k*es);
      end
    end
    return out;
  endfunction

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one operation and compare outputs one cycle later.
  task automatic run_op(input string req, input logic [255:0] a, input logic [255:0] b,
      input logic [255:0] o, input logic e32, input logic [1:0] vl, input logic t3,
      input logic m, input logic [47:0] ad);
    @(negedge clk);
    src_a = a; src_b = b; dst_old = o; elem32 = e32; vlen = vl;
    three_op = t3; src_b_mem = m; src_b_addr = ad; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " res"}, res, ref_res(a, b, o, e32, vl, t3, m, ad));
    chk({req, " fault"}, 256'(fault), 256'(ref_flt(m, vl, t3, ad)));
    chk({req, " valid"}, 256'(out_valid), 256'd1);
  endtask

  task automatic t_reset();
    chk("R11 reset res", res, '0);
    chk("R11 reset fault", 256'(fault), 256'd0);
    chk("R11 reset valid", 256'(out_valid), 256'd0);
  endtask

  task automatic t_words128();
    logic [255:0] a = {128'h0, 16'd80, 16'd100, 16'd7, 16'd3, 16'd1, 16'd1, 16'd5, 16'd9};
    logic [255:0] b = {128'h0, 16'd2, 16'd1, 16'd10, 16'd30, 16'd0, 16'd4, 16'd6, 16'd6};
    logic [255:0] o = rnd256();
    run_op("R1 R2 R3 R5 word128", a, b, o, 1'b0, 2'b01, 1'b0, 1'b0, 48'h0);
    chk("R3 a pair0 at word0", 256'(res[15:0]), 256'(16'd4));
    chk("R3 b pair3 at word7", 256'(res[127:112]), 256'(16'hFFFF));
  endtask

  task automatic t_dwords128();
    logic [255:0] a = {128'h0, 32'd1, 32'd10, 32'd100, 32'd40};
    logic [255:0] b = {128'h0, 32'd7, 32'd5, 32'd3, 32'd8};
    run_op("R2 R3 dword128", a, b, rnd256(), 1'b1, 2'b01, 1'b1, 1'b0, 48'h0);
    chk("R2 dword a pair0", 256'(res[31:0]), 256'(32'hFFFF_FFC4));
    chk("R6 upper zero", 256'(res[255:128]), '0);
  endtask

  task automatic t_narrow();
    run_op("R4 word64", rnd256(), rnd256(), rnd256(), 1'b0, 2'b00, 1'b0, 1'b0, 48'h0);
    run_op("R4 dword64", rnd256(), rnd256(), rnd256(), 1'b1, 2'b00, 1'b1, 1'b1, 48'h3);
  endtask

  task automatic t_wide();
    logic [255:0] a = rnd256();
    run_op("R7 word256 legacy", a, rnd256(), rnd256(), 1'b0, 2'b10, 1'b0, 1'b0, 48'h0);
    run_op("R7 dword256 three-op", a, rnd256(), rnd256(), 1'b1, 2'b11, 1'b1, 1'b0, 48'h0);
    // Boundary pair: elements at bits 127:96 and 159:128 must not pair.
    a = '0; a[159:128] = 32'd5;
    run_op("R7 no cross-region", a, '0, '0, 1'b1, 2'b10, 1'b0, 1'b0, 48'h0);
    chk("R7 region1 low", 256'(res[159:128]), 256'(32'd5));
  endtask

  task automatic t_fault();
    logic [255:0] o = rnd256();
    run_op("R8 misaligned", rnd256(), rnd256(), o, 1'b0, 2'b01, 1'b0, 1'b1, 48'h1008);
    chk("R8 res is old", res, o);
    run_op("R9 aligned mem", rnd256(), rnd256(), rnd256(), 1'b0, 2'b01, 1'b0, 1'b1, 48'h1010);
    run_op("R9 three-op misaligned", rnd256(), rnd256(), rnd256(), 1'b1, 2'b01, 1'b1, 1'b1, 48'h7);
    run_op("R9 256 misaligned", rnd256(), rnd256(), rnd256(), 1'b0, 2'b10, 1'b0, 1'b1, 48'h5);
    run_op("R9 reg source", rnd256(), rnd256(), rnd256(), 1'b0, 2'b01, 1'b0, 1'b0, 48'hF);
  endtask

  task automatic t_wrap();
    logic [255:0] a = '0;
    logic [255:0] b = '0;
    a[31:0] = {16'h0001, 16'h8000};
    a[63:32] = {16'hFFFF, 16'h7FFF};
    run_op("R10 word wrap", a, b, '0, 1'b0, 2'b01, 1'b1, 1'b0, 48'h0);
    chk("R10 8000-0001", 256'(res[15:0]), 256'(16'h7FFF));
    chk("R10 7FFF-FFFF", 256'(res[31:16]), 256'(16'h8000));
    a = '0; a[63:0] = {32'h0000_0001, 32'h8000_0000};
    run_op("R10 dword wrap", a, b, '0, 1'b1, 2'b01, 1'b1, 1'b0, 48'h0);
    chk("R10 80000000-1", 256'(res[31:0]), 256'(32'h7FFF_FFFF));
  endtask

  task automatic t_timing();
    logic [255:0] held;
    run_op("R11 op", rnd256(), rnd256(), rnd256(), 1'b0, 2'b01, 1'b0, 1'b0, 48'h0);
    held = res;
    src_a = rnd256(); src_b = rnd256(); dst_old = rnd256(); src_b_mem = 1'b1;
    src_b_addr = 48'h3;
    @(negedge clk);
    chk("R11 valid one cycle", 256'(out_valid), 256'd0);
    chk("R11 res held", res, held);
    chk("R11 fault held", 256'(fault), 256'd0);
  endtask

  task automatic t_random();
    for (int n = 0; n < 60; n++) begin
      logic [47:0] ad = 48'($urandom());
      if (n % 3 == 0) ad[3:0] = 4'h0;
      run_op("R1 R3 random", rnd256(), rnd256(), rnd256(), 1'($urandom()), 2'($urandom()),
             1'($urandom()), 1'($urandom()), ad);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_words128();
    t_dwords128();
    t_narrow();
    t_wide();
    t_fault();
    t_wrap();
    t_timing();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule